// File: doc/BRIEF.md
# NAND Command Sequencer

This block runs one NAND flash operation from start to finish, started by a single packed control word written through a 32-bit register port. It places the first opcode on the bus with the command latch, then 0 to 5 address bytes, then, as selected, a read or write data phase of programmable length and a second opcode byte. One of two chip enables is active for the whole operation. Program, erase and large-page read are two-phase flash commands, and each runs as one hardware operation: a separate register arms the trailing opcode, so software writes no second control word.

After any closing command byte the sequencer waits a fixed settle window and then follows the flash ready/busy line. Read data goes out as a byte stream with a push strobe, and write data comes in from a byte source with a pop strobe. When the operation ends, a sticky interrupt bit is set and the interrupt output goes high. Bus timing comes from fixed parameters (strobe low time, strobe high time, settle window), so there are no timing registers.

Top module: `nand_op_seq`

## Requirements
- R1: Writing word index 0 (control) with bit 31 set while idle starts an operation. Bits 7:0 are sent first as a command byte: CLE high and WE# pulsed low. The status register (word index 6) reads bit 0 = 1 while the operation runs. The control register reads back the written word with bit 31 cleared once the operation ends.
- R2: Control bit 30 enables address cycles, and bits 29:27 hold the cycle count minus one. The address bytes go out with ALE high, in this order: column low byte, column high byte (column register, index 3, bits 15:0), then row bytes 0, 1, 2 (row register, index 4, bits 23:0). When bit 30 is clear, no address cycle is sent.
- R3: Control bit 19 set drives CE1# low for the operation, and bit 19 clear drives CE0# low. The other enable stays high, and both are never low at once.
- R4: Control bit 26 selects a read phase. There are length+1 RE# pulses (length register, index 2). Each byte on the IO input is pushed out with `rbuf_push` while RE# is low.
- R5: Control bit 25 (with bit 26 clear) selects a write phase. There are length+1 WE# pulses, each carrying the next `wbuf_data` byte with the IO output enabled, and one `wbuf_pop` per byte.
- R6: Command register (index 1) bit 8 arms a second command byte, with the opcode in bits 7:0. On reads it is sent after the address cycles. On writes it is sent after the data phase. When bit 8 is clear it is never sent.
- R7: After a second command byte, or after a lone command with no data phase, the sequencer waits at least 25 clock cycles (100 ns) before it samples R/B#. A read data phase starts only once R/B# is high again, and completion is held until then.
- R8: Completion sets bit 31 of the interrupt register (index 5) and raises `irq`. Writing 1 to bit 31 clears it. Writing 0 leaves it set.
- R9: A control write while an operation is running is ignored: the stored word does not change and no extra bus cycle is issued.
- R10: After reset both chip enables, WE# and RE# are high, CLE, ALE and the IO output enable are low, `irq` is low and status bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Completion interrupt (sticky) |
| nd_ce0_n | output | 1 | Chip enable 0, active low |
| nd_ce1_n | output | 1 | Chip enable 1, active low |
| nd_cle | output | 1 | Command latch enable |
| nd_ale | output | 1 | Address latch enable |
| nd_we_n | output | 1 | Write strobe, active low |
| nd_re_n | output | 1 | Read strobe, active low |
| nd_rb_n | input | 1 | Ready (high) / busy (low) from flash |
| nd_io_in | input | 8 | IO bus input from flash |
| nd_io_out | output | 8 | IO bus output to flash |
| nd_io_oe | output | 1 | IO bus output enable |
| wbuf_data | input | 8 | Next write byte from page buffer |
| wbuf_pop | output | 1 | Write byte consumed |
| rbuf_data | output | 8 | Read byte to page buffer |
| rbuf_push | output | 1 | Read byte valid |

## Verification
The bench model pulls R/B# low only 8 cycles after the closing opcode. A sequencer that sampled the line before the settle window ran out would see it still high and pulse RE# before the flash is ready, and the bench compares the first RE# fall with the R/B# rise. The position of the second opcode is logged against the address and data counts, so a write that sent it before its data, or a read that sent it after data, is caught. Further cases are a disarmed second opcode that must not appear, a command-only operation with no address and no data, a five-byte address whose byte order is checked, a control write issued mid-operation that must neither restart nor overwrite, and write-1-to-clear tried with both 0 and 1.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD1,
        S_ADDR,
        S_CMD2,
        S_TWB,
        S_RB,
        S_RDAT,
        S_WDAT
    } seq_st_e;

    // register word indices
    localparam logic [2:0] RG_CTRL = 3'd0;
    localparam logic [2:0] RG_CMD2 = 3'd1;
    localparam logic [2:0] RG_LEN  = 3'd2;
    localparam logic [2:0] RG_COL  = 3'd3;
    localparam logic [2:0] RG_ROW  = 3'd4;
    localparam logic [2:0] RG_INT  = 3'd5;
    localparam logic [2:0] RG_STAT = 3'd6;

    // control word bit positions
    localparam int CB_GO    = 31;
    localparam int CB_ADEN  = 30;
    localparam int CB_RD    = 26;
    localparam int CB_WR    = 25;
    localparam int CB_CESEL = 19;
    localparam int C2_EN    = 8;

endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
    import nand_seq_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             busy,
    input  logic             done,
    output logic             start,
    output logic [8:0]       cmd2_cfg,
    output logic [LEN_W-1:0] len_cfg,
    output logic [15:0]      col_cfg,
    output logic [23:0]      row_cfg,
    output logic             irq
);

    typedef struct packed {
        logic [31:0]      ctrl;
        logic [8:0]       cmd2;
        logic [LEN_W-1:0] len;
        logic [15:0]      col;
        logic [23:0]      row;
        logic             intr;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d     = q;
        start = reg_we && (reg_addr == RG_CTRL) && reg_wdata[CB_GO] && !busy;
        if (reg_we) begin
            case (reg_addr)
                RG_CTRL: if (!busy) d.ctrl = reg_wdata;
                RG_CMD2: d.cmd2 = reg_wdata[8:0];
                RG_LEN:  d.len  = reg_wdata[LEN_W-1:0];
                RG_COL:  d.col  = reg_wdata[15:0];
                RG_ROW:  d.row  = reg_wdata[23:0];
                RG_INT:  if (reg_wdata[31]) d.intr = 1'b0;
                default: ;
            endcase
        end
        if (done) begin
            d.intr         = 1'b1;
            d.ctrl[CB_GO]  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            RG_CTRL: reg_rdata = q.ctrl;
            RG_CMD2: reg_rdata = {23'd0, q.cmd2};
            RG_LEN:  reg_rdata = {{(32-LEN_W){1'b0}}, q.len};
            RG_COL:  reg_rdata = {16'd0, q.col};
            RG_ROW:  reg_rdata = {8'd0, q.row};
            RG_INT:  reg_rdata = {q.intr, 31'd0};
            RG_STAT: reg_rdata = {31'd0, busy};
            default: reg_rdata = '0;
        endcase
    end

    assign cmd2_cfg = q.cmd2;
    assign len_cfg  = q.len;
    assign col_cfg  = q.col;
    assign row_cfg  = q.row;
    assign irq      = q.intr;

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int T_LOW   = 2,
    parameter int T_HIGH  = 2,
    parameter int TWB_CYC = 25,
    parameter int LEN_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      start_word,
    input  logic [8:0]       cmd2_cfg,
    input  logic [LEN_W-1:0] len_cfg,
    input  logic [15:0]      col_cfg,
    input  logic [23:0]      row_cfg,
    input  logic             nd_rb_n,
    input  logic [7:0]       nd_io_in,
    input  logic [7:0]       wbuf_data,
    output logic             busy,
    output logic             done,
    output logic             nd_ce0_n,
    output logic             nd_ce1_n,
    output logic             nd_cle,
    output logic             nd_ale,
    output logic             nd_we_n,
    output logic             nd_re_n,
    output logic [7:0]       nd_io_out,
    output logic             nd_io_oe,
    output logic             wbuf_pop,
    output logic             rbuf_push,
    output logic [7:0]       rbuf_data
);

    localparam int CYC     = T_LOW + T_HIGH;
    localparam int CNT_MAX = (CYC > TWB_CYC) ? CYC : TWB_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_st_e          st;
        logic [CW-1:0]    cnt;
        logic [2:0]       aidx;
        logic [LEN_W-1:0] bcnt;
        logic [7:0]       opc1;
        logic [7:0]       opc2;
        logic             c2en;
        logic             rd;
        logic             wr;
        logic             aen;
        logic [2:0]       alast;
        logic             cesel;
        logic [LEN_W-1:0] len;
        logic [39:0]      addr;
        logic [1:0]       rb_s;
    } fsm_t;

    fsm_t q, d;

    logic    cyc_end;
    seq_st_e post_addr;
    logic    unused_bits;

    assign unused_bits = ^{start_word[24:20], start_word[18:8]};
    assign cyc_end     = (q.cnt == CW'(CYC - 1));

    always_comb begin
        if (q.rd)      post_addr = q.c2en ? S_CMD2 : S_RDAT;
        else if (q.wr) post_addr = S_WDAT;
        else           post_addr = q.c2en ? S_CMD2 : S_TWB;
    end

    always_comb begin
        d      = q;
        done   = 1'b0;
        d.rb_s = {q.rb_s[0], nd_rb_n};
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st    = S_CMD1;
                    d.cnt   = '0;
                    d.aidx  = '0;
                    d.bcnt  = '0;
                    d.opc1  = start_word[7:0];
                    d.rd    = start_word[CB_RD];
                    d.wr    = start_word[CB_WR] && !start_word[CB_RD];
                    d.aen   = start_word[CB_ADEN];
                    d.alast = start_word[29:27];
                    d.cesel = start_word[CB_CESEL];
                    d.c2en  = cmd2_cfg[C2_EN];
                    d.opc2  = cmd2_cfg[7:0];
                    d.len   = len_cfg;
                    d.addr  = {row_cfg, col_cfg};
                end
            end
            S_CMD1: begin
                d.cnt = cyc_end ? '0 : q.cnt + 1'b1;
                if (cyc_end) d.st = q.aen ? S_ADDR : post_addr;
            end
            S_ADDR: begin
                d.cnt = cyc_end ? '0 : q.cnt + 1'b1;
                if (cyc_end) begin
                    if (q.aidx == q.alast) d.st = post_addr;
                    else                   d.aidx = q.aidx + 1'b1;
                end
            end
            S_CMD2: begin
                d.cnt = cyc_end ? '0 : q.cnt + 1'b1;
                if (cyc_end) d.st = S_TWB;
            end
            S_TWB: begin
                if (q.cnt == CW'(TWB_CYC - 1)) begin
                    d.cnt = '0;
                    d.st  = S_RB;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_RB: begin
                if (q.rb_s[1]) begin
                    if (q.rd) begin
                        d.st = S_RDAT;
                    end else begin
                        d.st = S_IDLE;
                        done = 1'b1;
                    end
                end
            end
            S_RDAT: begin
                d.cnt = cyc_end ? '0 : q.cnt + 1'b1;
                if (cyc_end) begin
                    if (q.bcnt == q.len) begin
                        d.st = S_IDLE;
                        done = 1'b1;
                    end else begin
                        d.bcnt = q.bcnt + 1'b1;
                    end
                end
            end
            S_WDAT: begin
                d.cnt = cyc_end ? '0 : q.cnt + 1'b1;
                if (cyc_end) begin
                    if (q.bcnt != q.len) begin
                        d.bcnt = q.bcnt + 1'b1;
                    end else if (q.c2en) begin
                        d.st = S_CMD2;
                    end else begin
                        d.st = S_IDLE;
                        done = 1'b1;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.rb_s <= 2'b11;
        end else begin
            q <= d;
        end
    end

    // pin decode from registered state
    logic        cmd_ph, adr_ph, wdat_ph, rdat_ph, lo_ph;
    logic [39:0] addr_sh;

    assign cmd_ph  = (q.st == S_CMD1) || (q.st == S_CMD2);
    assign adr_ph  = (q.st == S_ADDR);
    assign wdat_ph = (q.st == S_WDAT);
    assign rdat_ph = (q.st == S_RDAT);
    assign lo_ph   = (q.cnt < CW'(T_LOW));
    assign addr_sh = q.addr >> {q.aidx, 3'b000};

    assign busy     = (q.st != S_IDLE);
    assign nd_ce0_n = !(busy && !q.cesel);
    assign nd_ce1_n = !(busy && q.cesel);
    assign nd_cle   = cmd_ph;
    assign nd_ale   = adr_ph;
    assign nd_we_n  = !((cmd_ph || adr_ph || wdat_ph) && lo_ph);
    assign nd_re_n  = !(rdat_ph && lo_ph);
    assign nd_io_oe = cmd_ph || adr_ph || wdat_ph;

    always_comb begin
        case (q.st)
            S_CMD1:  nd_io_out = q.opc1;
            S_CMD2:  nd_io_out = q.opc2;
            S_ADDR:  nd_io_out = addr_sh[7:0];
            S_WDAT:  nd_io_out = wbuf_data;
            default: nd_io_out = 8'h00;
        endcase
    end

    assign wbuf_pop  = wdat_ph && cyc_end;
    assign rbuf_push = rdat_ph && (q.cnt == CW'(T_LOW - 1));
    assign rbuf_data = nd_io_in;

endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
    import nand_seq_pkg::*;
#(
    parameter int T_LOW   = 2,
    parameter int T_HIGH  = 2,
    parameter int TWB_CYC = 25,
    parameter int LEN_W   = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        nd_ce0_n,
    output logic        nd_ce1_n,
    output logic        nd_cle,
    output logic        nd_ale,
    output logic        nd_we_n,
    output logic        nd_re_n,
    input  logic        nd_rb_n,
    input  logic [7:0]  nd_io_in,
    output logic [7:0]  nd_io_out,
    output logic        nd_io_oe,
    input  logic [7:0]  wbuf_data,
    output logic        wbuf_pop,
    output logic [7:0]  rbuf_data,
    output logic        rbuf_push
);

    logic             seq_busy;
    logic             seq_done;
    logic             seq_start;
    logic [8:0]       cmd2_cfg;
    logic [LEN_W-1:0] len_cfg;
    logic [15:0]      col_cfg;
    logic [23:0]      row_cfg;

    nand_seq_regs #(.LEN_W(LEN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (seq_busy),
        .done      (seq_done),
        .start     (seq_start),
        .cmd2_cfg  (cmd2_cfg),
        .len_cfg   (len_cfg),
        .col_cfg   (col_cfg),
        .row_cfg   (row_cfg),
        .irq       (irq)
    );

    nand_seq_fsm #(
        .T_LOW   (T_LOW),
        .T_HIGH  (T_HIGH),
        .TWB_CYC (TWB_CYC),
        .LEN_W   (LEN_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (seq_start),
        .start_word (reg_wdata),
        .cmd2_cfg   (cmd2_cfg),
        .len_cfg    (len_cfg),
        .col_cfg    (col_cfg),
        .row_cfg    (row_cfg),
        .nd_rb_n    (nd_rb_n),
        .nd_io_in   (nd_io_in),
        .wbuf_data  (wbuf_data),
        .busy       (seq_busy),
        .done       (seq_done),
        .nd_ce0_n   (nd_ce0_n),
        .nd_ce1_n   (nd_ce1_n),
        .nd_cle     (nd_cle),
        .nd_ale     (nd_ale),
        .nd_we_n    (nd_we_n),
        .nd_re_n    (nd_re_n),
        .nd_io_out  (nd_io_out),
        .nd_io_oe   (nd_io_oe),
        .wbuf_pop   (wbuf_pop),
        .rbuf_push  (rbuf_push),
        .rbuf_data  (rbuf_data)
    );

endmodule

// File: rtl/nand_op_seq_chk.sv
module nand_op_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        irq,
    input logic        nd_ce0_n,
    input logic        nd_ce1_n,
    input logic        nd_cle,
    input logic        nd_ale,
    input logic        nd_we_n,
    input logic        nd_re_n,
    input logic        nd_io_oe,
    input logic        wbuf_pop,
    input logic        rbuf_push
);

    // R3
    ce_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nd_ce0_n && !nd_ce1_n));

    // R2
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nd_cle && nd_ale));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nd_we_n && !nd_re_n));

    // R4
    push_in_re_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rbuf_push |-> (!nd_re_n && !nd_io_oe));

    // R5
    pop_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wbuf_pop |-> (nd_io_oe && nd_we_n));

    // R10
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nd_ce0_n && nd_ce1_n && nd_we_n && nd_re_n && !nd_io_oe));

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_we && reg_addr == 3'd5 && reg_wdata[31])) |=> irq);

endmodule

bind nand_op_seq nand_op_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (seq_busy),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .nd_ce0_n  (nd_ce0_n),
    .nd_ce1_n  (nd_ce1_n),
    .nd_cle    (nd_cle),
    .nd_ale    (nd_ale),
    .nd_we_n   (nd_we_n),
    .nd_re_n   (nd_re_n),
    .nd_io_oe  (nd_io_oe),
    .wbuf_pop  (wbuf_pop),
    .rbuf_push (rbuf_push)
);

// File: tb/nand_op_seq_bench.sv
module nand_op_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        nd_ce0_n, nd_ce1_n, nd_cle, nd_ale, nd_we_n, nd_re_n;
    logic        nd_rb_n = 1'b1;
    logic [7:0]  nd_io_in;
    logic [7:0]  nd_io_out;
    logic        nd_io_oe;
    logic [7:0]  wbuf_data;
    logic        wbuf_pop;
    logic [7:0]  rbuf_data;
    logic        rbuf_push;

    always #2 clk = ~clk;

    nand_op_seq u_nand_op_seq (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .nd_ce0_n(nd_ce0_n), .nd_ce1_n(nd_ce1_n), .nd_cle(nd_cle),
        .nd_ale(nd_ale), .nd_we_n(nd_we_n), .nd_re_n(nd_re_n),
        .nd_rb_n(nd_rb_n), .nd_io_in(nd_io_in), .nd_io_out(nd_io_out),
        .nd_io_oe(nd_io_oe), .wbuf_data(wbuf_data), .wbuf_pop(wbuf_pop),
        .rbuf_data(rbuf_data), .rbuf_push(rbuf_push)
    );

    int n_chk = 0;
    int n_bad = 0;

    // flash / buffer model state
    logic [7:0] cmd_log [8];
    int         adr_at_cmd [8];
    int         wr_at_cmd [8];
    logic [7:0] adr_log [8];
    logic [7:0] wr_log [16];
    logic [7:0] rd_log [16];
    int ncmd, nadr, nwr, nrd;
    int cyc = 0;
    int rd_idx, pop_cnt;
    int rb_timer, rb_low;
    int rb_rise_cyc, first_re_cyc, irq_cyc;
    logic [7:0] busy_op;
    bit  busy_arm, ce0_seen, ce1_seen;
    logic pwe = 1'b1, pre = 1'b1, pirq = 1'b0;

    assign nd_io_in  = 8'hA0 + rd_idx[7:0];
    assign wbuf_data = 8'h50 + pop_cnt[7:0];

    always @(negedge clk) begin
        cyc++;
        if (!pwe && nd_we_n) begin
            if (nd_cle) begin
                if (ncmd < 8) begin
                    cmd_log[ncmd]    = nd_io_out;
                    adr_at_cmd[ncmd] = nadr;
                    wr_at_cmd[ncmd]  = nwr;
                end
                ncmd++;
                if (busy_arm && nd_io_out == busy_op) rb_timer = 8;
            end else if (nd_ale) begin
                if (nadr < 8) adr_log[nadr] = nd_io_out;
                nadr++;
            end else if (nd_io_oe) begin
                if (nwr < 16) wr_log[nwr] = nd_io_out;
                nwr++;
            end
        end
        if (pre && !nd_re_n && first_re_cyc < 0) first_re_cyc = cyc;
        if (!pre && nd_re_n) rd_idx++;
        if (rbuf_push) begin
            if (nrd < 16) rd_log[nrd] = rbuf_data;
            nrd++;
        end
        if (wbuf_pop) pop_cnt++;
        if (rb_timer > 0) begin
            rb_timer--;
            if (rb_timer == 0) begin
                nd_rb_n = 1'b0;
                rb_low  = 40;
            end
        end else if (rb_low > 0) begin
            rb_low--;
            if (rb_low == 0) begin
                nd_rb_n     = 1'b1;
                rb_rise_cyc = cyc;
            end
        end
        if (!nd_ce0_n) ce0_seen = 1'b1;
        if (!nd_ce1_n) ce1_seen = 1'b1;
        if (irq && !pirq) irq_cyc = cyc;
        pwe  = nd_we_n;
        pre  = nd_re_n;
        pirq = irq;
    end

    task automatic check(input bit ok, input string req, input logic [39:0] act,
                         input logic [39:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic clear_log(input logic [7:0] bop, input bit arm);
        @(negedge clk);
        ncmd = 0; nadr = 0; nwr = 0; nrd = 0;
        rd_idx = 0; pop_cnt = 0; rb_timer = 0; rb_low = 0;
        rb_rise_cyc = -1; first_re_cyc = -1; irq_cyc = -1;
        busy_op = bop; busy_arm = arm; ce0_seen = 0; ce1_seen = 0;
    endtask

    task automatic wait_irq();
        while (!irq) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check(nd_ce0_n && nd_ce1_n && nd_we_n && nd_re_n, "R10 strobes",
              {nd_ce0_n, nd_ce1_n, nd_we_n, nd_re_n}, 4'hF);
        check(!nd_cle && !nd_ale && !nd_io_oe && !irq, "R10 latches/irq",
              {nd_cle, nd_ale, nd_io_oe, irq}, 0);
        rd_reg(3'd6, v);
        check(v == 0, "R10 status", v, 0);
    endtask

    task automatic t_id_read();
        logic [31:0] v;
        clear_log(8'h00, 1'b0);
        wr_reg(3'd1, 32'h0);
        wr_reg(3'd2, 32'd4);
        wr_reg(3'd3, 32'h0);
        wr_reg(3'd0, 32'hC400_0090);
        rd_reg(3'd6, v);
        check(v[0] == 1'b1, "R1 busy during op", v, 1);
        wait_irq();
        check(ncmd == 1 && cmd_log[0] == 8'h90, "R1 first opcode", cmd_log[0], 8'h90);
        check(nadr == 1 && adr_log[0] == 8'h00, "R2 one address byte", nadr, 1);
        check(nrd == 5, "R4 read byte count", nrd, 5);
        for (int i = 0; i < 5; i++)
            check(rd_log[i] == 8'hA0 + 8'(i), "R4 read byte", rd_log[i], 8'hA0 + 8'(i));
        check(ce0_seen && !ce1_seen, "R3 ce0 used", {ce0_seen, ce1_seen}, 2'b10);
        rd_reg(3'd0, v);
        check(v == 32'h4400_0090, "R1 control readback", v, 32'h4400_0090);
        rd_reg(3'd5, v);
        check(v[31] && irq, "R8 int set", v, 32'h8000_0000);
        wr_reg(3'd5, 32'h0);
        check(irq, "R8 write 0 keeps", irq, 1);
        wr_reg(3'd5, 32'h8000_0000);
        rd_reg(3'd5, v);
        check(!irq && v == 0, "R8 write 1 clears", v, 0);
    endtask

    task automatic t_page_read();
        clear_log(8'h30, 1'b1);
        wr_reg(3'd1, 32'h130);
        wr_reg(3'd2, 32'd7);
        wr_reg(3'd3, 32'h0834);
        wr_reg(3'd4, 32'h012345);
        wr_reg(3'd0, 32'hE408_0000);
        wait_irq();
        check(ncmd == 2 && cmd_log[0] == 8'h00 && cmd_log[1] == 8'h30,
              "R6 read opcodes", {cmd_log[0], cmd_log[1]}, 16'h0030);
        check(adr_at_cmd[1] == 5, "R6 second opcode after address", adr_at_cmd[1], 5);
        check(nadr == 5 && {adr_log[4], adr_log[3], adr_log[2], adr_log[1], adr_log[0]}
              == 40'h01_23_45_08_34, "R2 five address bytes",
              {adr_log[4], adr_log[3], adr_log[2], adr_log[1], adr_log[0]}, 40'h0123450834);
        check(nrd == 8 && rd_log[7] == 8'hA7, "R4 page read bytes", nrd, 8);
        check(ce1_seen && !ce0_seen, "R3 ce1 used", {ce0_seen, ce1_seen}, 2'b01);
        check(rb_rise_cyc > 0 && first_re_cyc > rb_rise_cyc, "R7 data waits for ready",
              first_re_cyc, rb_rise_cyc);
        wr_reg(3'd5, 32'h8000_0000);
    endtask

    task automatic t_program();
        logic [31:0] v;
        clear_log(8'h10, 1'b1);
        wr_reg(3'd1, 32'h110);
        wr_reg(3'd2, 32'd3);
        wr_reg(3'd3, 32'h0012);
        wr_reg(3'd4, 32'h000077);
        wr_reg(3'd0, 32'hD200_0080);
        wr_reg(3'd0, 32'hC400_0090);
        rd_reg(3'd6, v);
        check(v[0] == 1'b1, "R9 still busy", v, 1);
        wait_irq();
        check(ncmd == 2 && cmd_log[0] == 8'h80 && cmd_log[1] == 8'h10,
              "R9 no extra op", ncmd, 2);
        check(wr_at_cmd[1] == 4, "R6 second opcode after write data", wr_at_cmd[1], 4);
        check(nadr == 3 && adr_log[0] == 8'h12 && adr_log[1] == 8'h00 && adr_log[2] == 8'h77,
              "R2 three address bytes", {adr_log[0], adr_log[1], adr_log[2]}, 24'h120077);
        check(nwr == 4 && pop_cnt == 4, "R5 write byte count", nwr, 4);
        for (int i = 0; i < 4; i++)
            check(wr_log[i] == 8'h50 + 8'(i), "R5 write byte", wr_log[i], 8'h50 + 8'(i));
        check(nrd == 0, "R5 no read pushes", nrd, 0);
        check(rb_rise_cyc > 0 && irq_cyc > rb_rise_cyc, "R7 done after ready",
              irq_cyc, rb_rise_cyc);
        rd_reg(3'd0, v);
        check(v == 32'h5200_0080, "R9 control unchanged", v, 32'h5200_0080);
        wr_reg(3'd5, 32'h8000_0000);
    endtask

    task automatic t_cmd_only();
        clear_log(8'hFF, 1'b1);
        wr_reg(3'd1, 32'h0D0);
        wr_reg(3'd0, 32'h8000_00FF);
        wait_irq();
        check(ncmd == 1 && cmd_log[0] == 8'hFF, "R6 disarmed opcode not sent", ncmd, 1);
        check(nadr == 0 && nwr == 0 && nrd == 0, "R2 no address cycles", nadr, 0);
        check(rb_rise_cyc > 0 && irq_cyc > rb_rise_cyc, "R7 lone command waits",
              irq_cyc, rb_rise_cyc);
        wr_reg(3'd5, 32'h8000_0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_id_read();
        t_page_read();
        t_program();
        t_cmd_only();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule